// File: doc/BRIEF.md
# Ringing Lag Search Engine

This block measures how long a bang-bang clock recovery loop takes to swing from one side of its damped ringing to the other. It works on the single-bit stream that leaves a wide-bandwidth majority-vote filter behind the phase detector; that filter removes broadband noise but keeps the ringing. The block keeps a candidate lag, which is always even. Over each measurement window it counts how often the current bit agrees with the bit from half the candidate lag earlier. Each agreement adds one and each disagreement subtracts one. When half the lag lands on the zero crossing of that autocorrelation, the full lag lands on its dip, and the dip sits at half the loop's oscillation period.

The search is meant to run while the loop gain is held at its highest code. The gain controller reports this on `max_gain_ok`. Windows are only taken while that input is high. A positive sum moves the candidate up by two and a negative sum moves it down by two. A sum within a small dead band leaves it where it is. Windows are judged in groups of eight. When a group ends with a small net movement, the search stops, the result is copied into a reference lag for later gain adaptation, and `done` is raised.

Top module: `ring_lag_search`

## Requirements
- R1: After reset, `lag_est` is 16, `ref_lag` is 0 and `done` is 0.
- R2: A `start` pulse sets `lag_est` to 16, clears `done` and begins a new search on the following cycle. `lag_est` always stays even and within 4 to 64.
- R3: A window is WIN_LEN samples taken while searching. Each sample adds +1 when `filt_bit` equals the bit seen lag_est/2 cycles earlier, and -1 otherwise. At the window's last sample, a sum above DEADBAND raises the lag by 2 and a sum below -DEADBAND lowers it by 2. The lag does not move past 4 or 64. Any other sum leaves the lag unchanged.
- R4: Windows form groups of 8. A group ends with convergence when the number of upward moves minus downward moves in the group lies within -2 to +2. `done` rises on the same clock edge that closes that group's last window, and from then on no further windows are taken.
- R5: At convergence, `ref_lag` takes the converged lag. It keeps that value, including across later `start` pulses, until the next convergence.
- R6: While `max_gain_ok` is low, no samples are taken and `lag_est` holds. A window that is interrupted this way is discarded, and sampling resumes with a fresh window.
- R7: Once `done` is high, it stays high and `lag_est` ignores the input stream until the next `start`.
- R8: If `start` arrives on the same edge that closes a window, the window's verdict and any convergence it would cause are dropped, and the restart takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new search (one-cycle pulse) |
| max_gain_ok | input | 1 | High while the loop gain is held at its top code |
| filt_bit | input | 1 | Majority-vote filtered phase-detector bit |
| lag_est | output | 7 | Current candidate lag in cycles |
| ref_lag | output | 7 | Lag stored at the last convergence |
| done | output | 1 | Search has converged |

## Verification
The two functions that can fall in the same cycle are a restart and the closing of a window that would also end a group with convergence. The bench counts clock edges from a `start` pulse and raises a second `start` on the exact edge where the eighth window closes for a stream known to converge. It judges the outcome at the ports: `done` must stay low, `lag_est` must return to 16 and `ref_lag` must keep the previous result. The bench then checks that the restarted search converges exactly eight windows later. Square-wave streams of every even period that divides the window length are swept. For each one the expected lag and window count are computed from the closed-form correlation of a square wave.

// File: rtl/rls_pkg.sv
package rls_pkg;

  // Outcome of one correlation window
  typedef enum logic [1:0] {
    VERD_HOLD = 2'd0,
    VERD_UP   = 2'd1,
    VERD_DOWN = 2'd2
  } verdict_e;

endpackage

// File: rtl/rls_history.sv
// Delay line of past stream bits plus a selectable tap (bit idx cycles ago).
module rls_history #(
  parameter int HIST_D = 32,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [IDX_W-1:0] idx,
  output logic             tap_bit
);

  logic hist [HIST_D];

  for (genvar i = 0; i < HIST_D; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) hist[0] <= 1'b0;
        else     hist[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) hist[i] <= 1'b0;
        else     hist[i] <= hist[i-1];
      end
    end
  end

  always_comb begin
    tap_bit = 1'b0;
    for (int i = 0; i < HIST_D; i++) begin
      if (idx == IDX_W'(i + 1)) tap_bit = hist[i];
    end
  end

  // R3: the newest stage holds the previous input bit
  a_r3_history_head: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hist[0] == $past(din)));

endmodule

// File: rtl/rls_window.sv
// Signed agreement accumulator over one measurement window.
module rls_window
  import rls_pkg::*;
#(
  parameter int WIN_LEN  = 256,
  parameter int DEADBAND = 8,
  parameter int ACC_W    = 10,
  parameter int CNT_W    = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     en,
  input  logic     agree,
  output logic     verd_valid,
  output verdict_e verd
);

  localparam logic signed [ACC_W-1:0] DB_POS = ACC_W'(DEADBAND);
  localparam logic signed [ACC_W-1:0] DB_NEG = -DB_POS;
  localparam logic [CNT_W-1:0]        LAST   = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] inc;
  logic signed [ACC_W-1:0] sum_now;
  logic signed [ACC_W-1:0] cnt_s;
  logic                    last;

  assign inc     = agree ? ACC_W'(1) : {ACC_W{1'b1}};
  assign sum_now = acc_q + inc;
  assign last    = en && (cnt_q == LAST);
  assign cnt_s   = ACC_W'(cnt_q);

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (last) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      acc_q <= sum_now;
    end
  end

  always_comb begin
    verd_valid = last && !clr;
    if (sum_now > DB_POS)      verd = VERD_UP;
    else if (sum_now < DB_NEG) verd = VERD_DOWN;
    else                       verd = VERD_HOLD;
  end

  // R3: partial sum never exceeds the number of samples taken
  a_r3_acc_bound: assert property (@(posedge clk) disable iff (rst)
    (acc_q <= cnt_s) && (acc_q >= -cnt_s));

  // R6: a disabled window holds no partial progress on the next cycle
  a_r6_window_discard: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0) && (acc_q == '0));

endmodule

// File: rtl/rls_ctrl.sv
// Lag stepping, clamping, group convergence and reference capture.
module rls_ctrl
  import rls_pkg::*;
#(
  parameter int MIN_LAG   = 4,
  parameter int MAX_LAG   = 64,
  parameter int START_LAG = 16,
  parameter int GROUP_WIN = 8,
  parameter int NET_LIMIT = 2,
  parameter int LAG_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             gain_ok,
  input  logic             verd_valid,
  input  verdict_e         verd,
  output logic             run_q,
  output logic [LAG_W-1:0] lag_q,
  output logic [LAG_W-1:0] ref_q,
  output logic             done_q
);

  localparam int GRP_W = (GROUP_WIN > 1) ? $clog2(GROUP_WIN) : 1;
  localparam int NET_W = $clog2(GROUP_WIN + 1) + 1;
  localparam logic [LAG_W-1:0] LAG_START = LAG_W'(START_LAG);
  localparam logic [LAG_W-1:0] LAG_TOP   = LAG_W'(MAX_LAG - 2);
  localparam logic [LAG_W-1:0] LAG_BOT   = LAG_W'(MIN_LAG + 2);
  localparam logic [LAG_W-1:0] LAG_MIN   = LAG_W'(MIN_LAG);
  localparam logic [LAG_W-1:0] LAG_MAX   = LAG_W'(MAX_LAG);
  localparam logic [GRP_W-1:0] GRP_LAST  = GRP_W'(GROUP_WIN - 1);
  localparam logic signed [NET_W-1:0] NET_POS = NET_W'(NET_LIMIT);
  localparam logic signed [NET_W-1:0] NET_NEG = -NET_POS;

  logic [GRP_W-1:0]        grp_q;
  logic signed [NET_W-1:0] net_q;
  logic signed [NET_W-1:0] net_nx;
  logic [LAG_W-1:0]        lag_nx;
  logic                    step_up;
  logic                    step_dn;
  logic                    group_end;
  logic                    converge;

  always_comb begin
    step_up   = verd_valid && (verd == VERD_UP)   && (lag_q <= LAG_TOP);
    step_dn   = verd_valid && (verd == VERD_DOWN) && (lag_q >= LAG_BOT);
    lag_nx    = lag_q;
    if (step_up) lag_nx = lag_q + LAG_W'(2);
    if (step_dn) lag_nx = lag_q - LAG_W'(2);
    net_nx    = net_q + NET_W'(step_up) - NET_W'(step_dn);
    group_end = verd_valid && (grp_q == GRP_LAST);
    converge  = group_end && (net_nx <= NET_POS) && (net_nx >= NET_NEG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      lag_q  <= LAG_START;
      ref_q  <= '0;
      done_q <= 1'b0;
      grp_q  <= '0;
      net_q  <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      lag_q  <= LAG_START;
      done_q <= 1'b0;
      grp_q  <= '0;
      net_q  <= '0;
    end else if (verd_valid) begin
      lag_q <= lag_nx;
      if (group_end) begin
        grp_q <= '0;
        net_q <= '0;
        if (converge) begin
          done_q <= 1'b1;
          run_q  <= 1'b0;
          ref_q  <= lag_nx;
        end
      end else begin
        grp_q <= grp_q + GRP_W'(1);
        net_q <= net_nx;
      end
    end
  end

  // R2: lag stays even and inside the clamp range
  a_r2_lag_range: assert property (@(posedge clk) disable iff (rst)
    (lag_q >= LAG_MIN) && (lag_q <= LAG_MAX) && !lag_q[0]);

  // R3: outside a restart the lag only moves by exactly two
  a_r3_step_size: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && (lag_q != $past(lag_q))) |->
      ((lag_q == $past(lag_q) + LAG_W'(2)) || (lag_q == $past(lag_q) - LAG_W'(2))));

  // R4: a converged search takes no more windows
  a_r4_stop_on_done: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !run_q);

  // R5: the reference only changes as done rises, and then equals the lag
  a_r5_ref_capture: assert property (@(posedge clk) disable iff (rst)
    (ref_q != $past(ref_q)) |-> (done_q && !$past(done_q)));
  a_r5_ref_match: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (ref_q == lag_q));

  // R6: without maximum gain the lag holds
  a_r6_pause_hold: assert property (@(posedge clk) disable iff (rst)
    (!gain_ok && !start) |=> $stable(lag_q));

  // R7: done is sticky until the next start
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> done_q);

endmodule

// File: rtl/ring_lag_search.sv
// Finds the ringing lag of a bang-bang loop from its filtered detector bits.
module ring_lag_search
  import rls_pkg::*;
#(
  parameter int WIN_LEN   = 256,
  parameter int DEADBAND  = 8,
  parameter int MIN_LAG   = 4,
  parameter int MAX_LAG   = 64,
  parameter int START_LAG = 16,
  parameter int GROUP_WIN = 8,
  parameter int NET_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       max_gain_ok,
  input  logic       filt_bit,
  output logic [6:0] lag_est,
  output logic [6:0] ref_lag,
  output logic       done
);

  localparam int LAG_W  = $clog2(MAX_LAG + 1);
  localparam int HIST_D = MAX_LAG / 2;
  localparam int IDX_W  = $clog2(HIST_D + 1);
  localparam int ACC_W  = $clog2(WIN_LEN + 1) + 1;
  localparam int CNT_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [LAG_W-1:0] lag_q;
  logic [LAG_W-1:0] ref_q;
  logic             done_q;
  logic             run_q;
  logic             win_en;
  logic             past_bit;
  logic             agree;
  logic             verd_valid;
  verdict_e         verd;
  logic [IDX_W-1:0] half_lag;

  assign half_lag = IDX_W'(lag_q >> 1);
  assign win_en   = run_q && max_gain_ok;
  assign agree    = filt_bit ~^ past_bit;

  rls_history #(
    .HIST_D (HIST_D),
    .IDX_W  (IDX_W)
  ) u_history (
    .clk     (clk),
    .rst     (rst),
    .din     (filt_bit),
    .idx     (half_lag),
    .tap_bit (past_bit)
  );

  rls_window #(
    .WIN_LEN  (WIN_LEN),
    .DEADBAND (DEADBAND),
    .ACC_W    (ACC_W),
    .CNT_W    (CNT_W)
  ) u_window (
    .clk        (clk),
    .rst        (rst),
    .clr        (start),
    .en         (win_en),
    .agree      (agree),
    .verd_valid (verd_valid),
    .verd       (verd)
  );

  rls_ctrl #(
    .MIN_LAG   (MIN_LAG),
    .MAX_LAG   (MAX_LAG),
    .START_LAG (START_LAG),
    .GROUP_WIN (GROUP_WIN),
    .NET_LIMIT (NET_LIMIT),
    .LAG_W     (LAG_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .gain_ok    (max_gain_ok),
    .verd_valid (verd_valid),
    .verd       (verd),
    .run_q      (run_q),
    .lag_q      (lag_q),
    .ref_q      (ref_q),
    .done_q     (done_q)
  );

  assign lag_est = 7'(lag_q);
  assign ref_lag = 7'(ref_q);
  assign done    = done_q;

  // R8: a restart edge never leaves the block converged
  a_r8_start_wins: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && (lag_est == 7'(START_LAG))));

endmodule

// File: tb/ring_lag_search_bench.sv
module ring_lag_search_bench;

  localparam int WIN = 120;
  localparam int DB  = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic       gain;
  logic       filt;
  logic [6:0] lag_est;
  logic [6:0] ref_lag;
  logic       done;

  int vectors = 0;
  int fails   = 0;
  int period_sel = 0;
  int phase = 0;
  int prev_ref = 0;

  always #10 clk = ~clk;

  ring_lag_search #(
    .WIN_LEN  (WIN),
    .DEADBAND (DB)
  ) u_ring_lag_search (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .max_gain_ok (gain),
    .filt_bit    (filt),
    .lag_est     (lag_est),
    .ref_lag     (ref_lag),
    .done        (done)
  );

  // Square-wave stimulus (period 0 means a constant one)
  always @(negedge clk) begin
    if (period_sel == 0) filt = 1'b1;
    else                 filt = ((phase % period_sel) < (period_sel / 2));
    phase = phase + 1;
  end

  task automatic chk(input string rq, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  // Closed-form search model: square-wave correlation per window
  task automatic model(input int p, output int k, output int lag);
    int l;
    int net;
    int g;
    l = 16; net = 0; g = 0; k = -1;
    for (int w = 1; w <= 64; w++) begin
      int h;
      int s;
      int hm;
      int d;
      h = l / 2;
      if (p == 0) s = WIN;
      else begin
        hm = h % p;
        d  = (hm <= p / 2) ? hm : p - hm;
        s  = (WIN / p) * (p - 4 * d);
      end
      if (s > DB && l <= 62) begin l += 2; net++; end
      else if (s < -DB && l >= 6) begin l -= 2; net--; end
      g++;
      if (g == 8) begin
        if (k < 0 && net <= 2 && net >= -2) k = w;
        g = 0; net = 0;
      end
      if (k > 0) break;
    end
    lag = l;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_case(input int p);
    int k;
    int el;
    model(p, k, el);
    if (k < 0) begin
      chk("R4 model converges", 0, 1);
      return;
    end
    period_sel = p;
    repeat (40) @(negedge clk);
    pulse_start();
    chk("R2 lag after start", lag_est, 16);
    chk("R2 done cleared", done, 0);
    chk("R5 ref kept across start", ref_lag, prev_ref);
    repeat (k * WIN - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 done not early", done, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 done on group edge", done, 1);
    chk("R3 converged lag", lag_est, el);
    chk("R5 ref captured", ref_lag, el);
    prev_ref = el;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int periods [13] = '{0, 2, 4, 6, 8, 10, 12, 20, 24, 30, 40, 60, 120};
    rst = 1'b1; start = 1'b0; gain = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset lag", lag_est, 16);
    chk("R1 reset ref", ref_lag, 0);
    chk("R1 reset done", done, 0);

    // R3 R4 R5: sweep of square-wave periods, constant stream hits the top clamp
    foreach (periods[i]) run_case(periods[i]);

    // R6: gain drop mid-window freezes the lag and discards the window
    period_sel = 40;
    repeat (40) @(negedge clk);
    pulse_start();
    repeat (WIN + 10) @(negedge clk);
    chk("R6 lag after first window", lag_est, 18);
    gain = 1'b0;
    repeat (3 * WIN) @(negedge clk);
    chk("R6 lag held without gain", lag_est, 18);
    chk("R6 no done without gain", done, 0);
    gain = 1'b1;
    for (int c = 0; c < 20 * WIN && !done; c++) @(negedge clk);
    chk("R6 done after resume", done, 1);
    chk("R6 lag after resume", lag_est, 20);

    // R7: after done, a stream that would push the lag up has no effect
    period_sel = 0;
    repeat (3 * WIN) @(negedge clk);
    chk("R7 lag frozen", lag_est, 20);
    chk("R7 done sticky", done, 1);
    chk("R7 ref frozen", ref_lag, 20);

    // R8: start on the exact edge that would converge
    period_sel = 40;
    repeat (40) @(negedge clk);
    pulse_start();
    repeat (8 * WIN - 1) @(posedge clk);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    chk("R8 done suppressed", done, 0);
    chk("R8 lag restarted", lag_est, 16);
    chk("R8 ref unchanged", ref_lag, 20);
    repeat (8 * WIN - 1) @(posedge clk);
    @(negedge clk);
    chk("R8 restart not early", done, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 restart converges", done, 1);
    chk("R8 restart lag", lag_est, 20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule